// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This block chooses whether a protected supply rail is fed from the main supply or from a backup battery. It sees three digitised voltages as unsigned millivolt codes: the main supply, the battery and a trip threshold. From them it drives two switch enables, one for the main path and one for the battery path, and it never turns both on at once. When it changes source it first turns both switches off for one clock cycle, then turns on the new one.

A battery comparison with a ±30 mV band sits under the trip test. When the main supply is above the trip threshold, the main path is always used. Below the threshold, the block leaves the main path only when the main supply falls under the battery voltage less 30 mV. It returns from the battery only when the main supply rises past the battery voltage plus 30 mV, or climbs back over the trip threshold. This band of 60 mV stops the rail from flipping between sources.

The block also drives these status outputs:
- an active-low battery-on indicator,
- a reset request,
- a serial-bus inhibit,
- a two-bit mode code.

The mode code has a separate value for running from main power with no battery fitted. The voltage inputs are plain sampled levels with no handshake. They may change on any cycle, and the block re-evaluates them on every clock.

Top module: `bkup_switch_ctrl`

## Requirements
- R1: While main_mv > trip_mv, the main path is selected (main_sw_en=1, batt_sw_en=0), including when the battery path was active and main_mv is still inside the hysteresis band.
- R2: While main_mv <= trip_mv and main_mv >= batt_mv - 30 (a battery below 30 mV gives a lower limit of 0), a connected main path stays connected.
- R3: When main_mv <= trip_mv and main_mv < batt_mv - 30, the controller moves to the battery path.
- R4: Once on the battery path with main_mv <= trip_mv, it returns to main only when main_mv > batt_mv + 30. A value equal to batt_mv + 30 keeps the battery path.
- R5: main_sw_en and batt_sw_en are never both 1. Every change of source passes through exactly one cycle with both at 0.
- R6: batt_on_n is 0 exactly when main_sw_en is 1.
- R7: Whenever the main path is not connected (the idle cycle or the battery path), reset_req=1, bus_inhibit=1 and mode=2'b10.
- R8: With the main path connected, mode=2'b01 when main_mv > trip_mv and batt_mv == 0, and mode=2'b00 otherwise. reset_req and bus_inhibit are 0.
- R9: During and right after reset: main_sw_en=1, batt_sw_en=0, batt_on_n=0, reset_req=0, bus_inhibit=0, mode=2'b00.
- R10: An input change that requires a source swap turns off the active switch at the second rising edge after the change. It turns on the other switch at the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_mv | input | VW | Main supply level, mV |
| batt_mv | input | VW | Battery level, mV |
| trip_mv | input | VW | Trip threshold, mV |
| main_sw_en | output | 1 | Enable for the main-supply switch |
| batt_sw_en | output | 1 | Enable for the battery switch |
| batt_on_n | output | 1 | Low while main supply feeds the rail |
| reset_req | output | 1 | Reset request while in backup |
| bus_inhibit | output | 1 | Blocks serial-bus access while in backup |
| mode | output | 2 | 00 normal, 01 normal without battery, 10 backup |

## Verification
The bench targets the exact edges of the band.

| Input condition | Expected path | Error the case exposes |
|---|---|---|
| main_mv equal to batt_mv - 30 | main | a strict/non-strict mix-up would drop to battery here |
| main_mv equal to batt_mv + 30 | battery | a wrong comparison would return to main early |
| main_mv one millivolt past either limit | switch | a missing hysteresis would show up as switching at the wrong point |

It follows a swap cycle by cycle. A design without break-before-make would show both enables in the same state, or skip the idle cycle. A design with a wrong pipeline depth would move the edge away from the second and third clocks. A return over the trip threshold while the battery reads higher catches a design that only trusts the hysteresis. A zero battery reading catches a missing no-battery mode and a lower limit that wraps when the battery reads below 30 mV.

// File: rtl/bkup_pkg.sv
package bkup_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_NO_BATT = 2'b01,
    MODE_BACKUP  = 2'b10
  } mode_e;

  typedef enum logic [1:0] {
    SRC_MAIN   = 2'b00,
    SRC_GAP_TB = 2'b01,
    SRC_BATT   = 2'b10,
    SRC_GAP_TM = 2'b11
  } src_e;

  typedef struct packed {
    logic above_trip;
    logic below_lo;
    logic above_hi;
    logic batt_zero;
  } cmp_flags_t;

endpackage

// File: rtl/bkup_compare.sv
module bkup_compare #(
  parameter int VW      = 16,
  parameter int HYST_MV = 30
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [VW-1:0]         main_mv,
  input  logic [VW-1:0]         batt_mv,
  input  logic [VW-1:0]         trip_mv,
  output bkup_pkg::cmp_flags_t  flags
);
  import bkup_pkg::*;

  localparam logic [VW-1:0] HYST_V = VW'(HYST_MV);

  logic [VW-1:0] lo_thr;
  logic [VW:0]   hi_thr;
  cmp_flags_t    nxt;

  always_comb begin
    lo_thr = (batt_mv >= HYST_V) ? (batt_mv - HYST_V) : '0;
    hi_thr = {1'b0, batt_mv} + {1'b0, HYST_V};
    nxt.above_trip = main_mv > trip_mv;
    nxt.below_lo   = main_mv < lo_thr;
    nxt.above_hi   = {1'b0, main_mv} > hi_thr;
    nxt.batt_zero  = batt_mv == '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end

  assert_band_disjoint_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags.below_lo && flags.above_hi));

endmodule

// File: rtl/bkup_source_fsm.sv
module bkup_source_fsm (
  input  logic                  clk,
  input  logic                  rst_n,
  input  bkup_pkg::cmp_flags_t  flags,
  output bkup_pkg::src_e        src,
  output logic                  main_sw_en,
  output logic                  batt_sw_en
);
  import bkup_pkg::*;

  src_e src_q, src_d;
  logic want_main;

  always_comb begin
    case (src_q)
      SRC_MAIN, SRC_GAP_TM: want_main = flags.above_trip | ~flags.below_lo;
      default:              want_main = flags.above_trip | flags.above_hi;
    endcase
  end

  always_comb begin
    src_d = src_q;
    case (src_q)
      SRC_MAIN:   if (!want_main) src_d = SRC_GAP_TB;
      SRC_GAP_TB: src_d = SRC_BATT;
      SRC_BATT:   if (want_main)  src_d = SRC_GAP_TM;
      SRC_GAP_TM: src_d = SRC_MAIN;
      default:    src_d = SRC_MAIN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= SRC_MAIN;
    else        src_q <= src_d;
  end

  assign src        = src_q;
  assign main_sw_en = (src_q == SRC_MAIN);
  assign batt_sw_en = (src_q == SRC_BATT);

  assert_never_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_sw_en && batt_sw_en));

  assert_gap_before_batt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (main_sw_en && !flags.above_trip && flags.below_lo) |=> (!main_sw_en && !batt_sw_en));

  assert_leave_batt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_sw_en && flags.above_hi) |=> !batt_sw_en);

endmodule

// File: rtl/bkup_mode_enc.sv
module bkup_mode_enc (
  input  logic                  clk,
  input  logic                  rst_n,
  input  bkup_pkg::src_e        src,
  input  bkup_pkg::cmp_flags_t  flags,
  output logic [1:0]            mode,
  output logic                  reset_req,
  output logic                  bus_inhibit
);
  import bkup_pkg::*;

  logic backup;
  mode_e m;

  always_comb begin
    backup = (src != SRC_MAIN);
    if (backup)                                m = MODE_BACKUP;
    else if (flags.above_trip && flags.batt_zero) m = MODE_NO_BATT;
    else                                       m = MODE_NORMAL;
  end

  assign mode        = m;
  assign reset_req   = backup;
  assign bus_inhibit = backup;

  assert_mode_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  assert_no_batt_mode_on_main_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (src == SRC_MAIN && !reset_req));

endmodule

// File: rtl/bkup_switch_ctrl.sv
module bkup_switch_ctrl #(
  parameter int VW      = 16,
  parameter int HYST_MV = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] main_mv,
  input  logic [VW-1:0] batt_mv,
  input  logic [VW-1:0] trip_mv,
  output logic          main_sw_en,
  output logic          batt_sw_en,
  output logic          batt_on_n,
  output logic          reset_req,
  output logic          bus_inhibit,
  output logic [1:0]    mode
);
  import bkup_pkg::*;

  cmp_flags_t flags;
  src_e       src;

  bkup_compare #(.VW(VW), .HYST_MV(HYST_MV)) u_cmp (
    .clk(clk), .rst_n(rst_n), .main_mv(main_mv), .batt_mv(batt_mv),
    .trip_mv(trip_mv), .flags(flags)
  );

  bkup_source_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .flags(flags), .src(src),
    .main_sw_en(main_sw_en), .batt_sw_en(batt_sw_en)
  );

  bkup_mode_enc u_mode (
    .clk(clk), .rst_n(rst_n), .src(src), .flags(flags),
    .mode(mode), .reset_req(reset_req), .bus_inhibit(bus_inhibit)
  );

  assign batt_on_n = ~main_sw_en;

  assert_backup_blocks_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (reset_req && bus_inhibit && batt_on_n));

  assert_trip_returns_main_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.above_trip && batt_sw_en) |=> !batt_sw_en);

endmodule

// File: tb/bkup_switch_ctrl_bench.sv
module bkup_switch_ctrl_bench;
  localparam int VW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [VW-1:0] main_mv = '0, batt_mv = '0, trip_mv = '0;
  logic main_sw_en, batt_sw_en, batt_on_n, reset_req, bus_inhibit;
  logic [1:0] mode;

  int n_chk = 0;
  int n_fail = 0;

  // {main_sw_en, batt_sw_en, batt_on_n, reset_req, bus_inhibit, mode}
  localparam logic [6:0] EXP_MAIN   = 7'b1_0_0_0_0_00;
  localparam logic [6:0] EXP_NOBATT = 7'b1_0_0_0_0_01;
  localparam logic [6:0] EXP_GAP    = 7'b0_0_1_1_1_10;
  localparam logic [6:0] EXP_BATT   = 7'b0_1_1_1_1_10;

  always #2.5 clk = ~clk;

  bkup_switch_ctrl #(.VW(VW)) u_bkup_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .main_mv(main_mv), .batt_mv(batt_mv),
    .trip_mv(trip_mv), .main_sw_en(main_sw_en), .batt_sw_en(batt_sw_en),
    .batt_on_n(batt_on_n), .reset_req(reset_req), .bus_inhibit(bus_inhibit),
    .mode(mode)
  );

  function automatic logic [6:0] obs();
    return {main_sw_en, batt_sw_en, batt_on_n, reset_req, bus_inhibit, mode};
  endfunction

  task automatic chk(input string req, input logic [6:0] exp_v);
    n_chk++;
    if (obs() !== exp_v) begin
      n_fail++;
      $display("FAIL %s: outputs %b, expected %b", req, obs(), exp_v);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic drive(input int m, input int b, input int t);
    @(negedge clk);
    main_mv = VW'(m); batt_mv = VW'(b); trip_mv = VW'(t);
  endtask

  task automatic t_reset();
    step(1);
    chk("R9 in reset", EXP_MAIN);
    rst_n = 1'b1;
    step(1);
    chk("R9 after reset", EXP_MAIN);
  endtask

  task automatic t_above_trip();
    drive(3500, 3000, 3300);
    step(4);
    chk("R1 above trip", EXP_MAIN);
    chk("R6 batt_on_n low on main", EXP_MAIN);
  endtask

  task automatic t_band_hold();
    drive(3100, 3000, 3300);
    step(4);
    chk("R2 below trip above batt", EXP_MAIN);
    drive(2970, 3000, 3300);
    step(4);
    chk("R2 equal to lower limit", EXP_MAIN);
  endtask

  task automatic t_to_batt();
    drive(2969, 3000, 3300);
    step(1);
    chk("R10 no change after first edge", EXP_MAIN);
    step(1);
    chk("R5 idle gap toward battery", EXP_GAP);
    step(1);
    chk("R3 battery connected", EXP_BATT);
    chk("R7 backup outputs", EXP_BATT);
  endtask

  task automatic t_return_band();
    drive(3030, 3000, 3300);
    step(4);
    chk("R4 equal to upper limit stays on battery", EXP_BATT);
    drive(3031, 3000, 3300);
    step(1);
    chk("R10 still battery after first edge", EXP_BATT);
    step(1);
    chk("R5 idle gap toward main", EXP_GAP);
    step(1);
    chk("R4 back on main", EXP_MAIN);
  endtask

  task automatic t_trip_return();
    drive(2000, 3500, 3300);
    step(4);
    chk("R3 deep drop", EXP_BATT);
    drive(3400, 3500, 3300);
    step(4);
    chk("R1 above trip inside band returns", EXP_MAIN);
  endtask

  task automatic t_no_batt();
    drive(3500, 0, 3300);
    step(3);
    chk("R8 no battery mode", EXP_NOBATT);
    drive(100, 0, 3300);
    step(4);
    chk("R8 below trip no battery stays normal", EXP_MAIN);
    drive(5, 20, 3300);
    step(4);
    chk("R2 small battery limit clamps to zero", EXP_MAIN);
  endtask

  initial begin
    t_reset();
    t_above_trip();
    t_band_hold();
    t_to_batt();
    t_return_band();
    t_trip_return();
    t_no_batt();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung, expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule